// File: doc/BRIEF.md
# Integer Add/Subtract Unit with Overflow Trap

This block is the add/subtract slice of an integer execution stage. One carry-propagate adder handles addition, subtraction and the magnitude compare behind set-on-less-than. Subtraction feeds the adder the bitwise complement of the second operand and forces the carry-in to one. The sum bits do not depend on the signed/unsigned mode. The mode changes only two things: whether an overflow raises a trap request, and how the compare reads the adder outputs.

An operation is presented with `in_valid` for one cycle. The result, the zero flag and the trap request appear registered on the next cycle, together with `out_valid`. The second operand comes either from `b_in` or from a 16-bit immediate. In signed mode the immediate is widened by copying its top bit into the upper bits. In unsigned mode the upper bits are filled with zeros. An overflow never changes the written result. It only pulses `ovf_trap`, and the exception handling that follows is outside this block.

Top module: `addsub_unit`

## Requirements
- R1: With `op` = 2'b00 (add), the result one cycle after a valid input is (A + B) modulo 2^32 and `out_valid` is high in that cycle. `op` = 2'b11 is reserved and behaves as add.
- R2: With `op` = 2'b01 (subtract), the result is (A - B) modulo 2^32, formed as A + ~B + 1. The bits are identical in signed and unsigned mode.
- R3: When `is_signed` is 0, add and subtract never raise `ovf_trap`, even when the unsigned or two's-complement value wraps.
- R4: A signed add raises `ovf_trap` exactly when both operands have the same sign and the sum has the opposite sign. The wrapped sum is still written.
- R5: A signed subtract raises `ovf_trap` exactly when A and B have different signs and the difference does not have the sign of A. This includes 0 minus the most negative value.
- R6: With `op` = 2'b10 and `is_signed` = 1, the result is 1 when A < B as two's-complement values and 0 otherwise, including at the most negative and most positive values. Set-on-less-than never raises `ovf_trap`.
- R7: With `op` = 2'b10 and `is_signed` = 0, the result is 1 when A < B as unsigned values and 0 otherwise.
- R8: `zero_flag` is 1 exactly when all 32 bits of the registered result are 0.
- R9: When `use_imm` is 1, the 16-bit `imm_in` replaces B. It is widened by copying bit 15 into bits 31:16 when `is_signed` is 1, and by filling bits 31:16 with zeros when `is_signed` is 0.
- R10: `ovf_trap` is high only in the cycle after a valid input that overflowed. A cycle with `in_valid` low gives `out_valid` = 0 and `ovf_trap` = 0 in the next cycle, and `result` and `zero_flag` keep their values.
- R11: After synchronous active-low reset, `out_valid`, `result`, `zero_flag` and `ovf_trap` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 2 | 00 add, 01 subtract, 10 set-on-less-than, 11 add |
| is_signed | input | 1 | 1 = signed mode, 0 = unsigned mode |
| use_imm | input | 1 | Take the second operand from `imm_in` |
| a_in | input | 32 | First operand |
| b_in | input | 32 | Second operand (register form) |
| imm_in | input | 16 | Immediate second operand |
| out_valid | output | 1 | Registered result is fresh |
| result | output | 32 | Registered result |
| zero_flag | output | 1 | Registered result is all zeros |
| ovf_trap | output | 1 | One-cycle signed overflow trap request |

## Verification
The main function is tried with sign-boundary operands: the largest positive plus one, the most negative minus one, and 0 minus the most negative. These separate a correct sign-comparison overflow rule from one applied to the complemented operand without inverting its sign. The same operand pairs are also run in unsigned mode, which shows that the mode changes only the trap and not the sum bits. Compare operands that straddle zero and the extremes separate signed ordering from unsigned ordering, and they show whether the less-than output uses the overflow correction. Random operands are checked against a 64-bit reference model. Immediates with bit 15 set separate sign extension from zero extension.

// File: rtl/addsub_pkg.sv
// Shared operation encoding for the add/subtract unit.
// Assumes a 2-bit operation field; the unused code is treated as add.
package addsub_pkg;
    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_SUB = 2'b01,
        OP_SLT = 2'b10,
        OP_RSV = 2'b11
    } addsub_op_e;
endpackage

// File: rtl/addsub_operand_ext.sv
// Second-operand selection: picks the register or the widened immediate,
// then complements it when the adder is to subtract.
// Assumes IMM_W <= W; the immediate is sign- or zero-extended by mode.
module addsub_operand_ext #(
    parameter int W     = 32,
    parameter int IMM_W = 16
) (
    input  logic [W-1:0]     b_reg,
    input  logic [IMM_W-1:0] imm,
    input  logic             use_imm,
    input  logic             is_signed,
    input  logic             invert,
    output logic [W-1:0]     b_adder,
    output logic             b_sign
);
    localparam int PAD = W - IMM_W;

    logic [W-1:0] imm_wide;
    logic [W-1:0] b_sel;

    generate
        if (PAD > 0) begin : g_pad
            // Widen the immediate: copy its top bit in signed mode, zeros otherwise.
            always_comb begin
                imm_wide = {{PAD{is_signed & imm[IMM_W-1]}}, imm};
            end
        end else begin : g_nopad
            // Immediate already spans the datapath width.
            always_comb begin
                imm_wide = imm[W-1:0];
            end
        end
    endgenerate

    // Choose the operand, then complement it for subtraction.
    always_comb begin
        b_sel   = use_imm ? imm_wide : b_reg;
        b_adder = invert ? ~b_sel : b_sel;
        b_sign  = b_sel[W-1];
    end
endmodule

// File: rtl/addsub_adder.sv
// Plain W-bit carry-propagate adder with carry-in and carry-out.
// Assumes nothing about the signedness of its inputs.
module addsub_adder #(
    parameter int W = 32
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    // Single shared addition for every operation.
    always_comb begin
        {cout, sum} = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
    end
endmodule

// File: rtl/addsub_flags.sv
// Derives signed overflow and the less-than bit from the adder outputs.
// Assumes the adder was given the complemented B and carry-in 1 for sub/slt.
module addsub_flags (
    input  logic a_sign,
    input  logic b_sign,
    input  logic sum_sign,
    input  logic cout,
    input  logic is_sub,
    input  logic is_signed,
    output logic ovf_raw,
    output logic less
);
    logic b_eff_sign;

    // Overflow from sign comparison; for subtraction B's sign is inverted.
    always_comb begin
        b_eff_sign = b_sign ^ is_sub;
        ovf_raw    = (a_sign == b_eff_sign) && (sum_sign != a_sign);
    end

    // Signed order corrects the sign with overflow; unsigned uses borrow.
    always_comb begin
        less = is_signed ? (sum_sign ^ ovf_raw) : ~cout;
    end
endmodule

// File: rtl/addsub_unit.sv
// Top of the add/subtract unit: one shared adder, registered outputs,
// one-cycle latency. Signed add/sub overflow requests a trap and leaves
// the result untouched. Assumes in_valid qualifies all other inputs.
module addsub_unit
    import addsub_pkg::*;
#(
    parameter int W     = 32,
    parameter int IMM_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [1:0]       op,
    input  logic             is_signed,
    input  logic             use_imm,
    input  logic [W-1:0]     a_in,
    input  logic [W-1:0]     b_in,
    input  logic [IMM_W-1:0] imm_in,
    output logic             out_valid,
    output logic [W-1:0]     result,
    output logic             zero_flag,
    output logic             ovf_trap
);
    addsub_op_e   op_e;
    logic         is_sub;
    logic         is_slt;
    logic [W-1:0] b_adder;
    logic         b_sign;
    logic [W-1:0] sum;
    logic         cout;
    logic         ovf_raw;
    logic         less;
    logic [W-1:0] res_next;
    logic         trap_next;

    // Decode the operation into datapath controls.
    always_comb begin
        op_e   = addsub_op_e'(op);
        is_slt = (op_e == OP_SLT);
        is_sub = (op_e == OP_SUB) || is_slt;
    end

    addsub_operand_ext #(.W(W), .IMM_W(IMM_W)) opnd_i (
        .b_reg     (b_in),
        .imm       (imm_in),
        .use_imm   (use_imm),
        .is_signed (is_signed),
        .invert    (is_sub),
        .b_adder   (b_adder),
        .b_sign    (b_sign)
    );

    addsub_adder #(.W(W)) adder_i (
        .x    (a_in),
        .y    (b_adder),
        .cin  (is_sub),
        .sum  (sum),
        .cout (cout)
    );

    addsub_flags flags_i (
        .a_sign    (a_in[W-1]),
        .b_sign    (b_sign),
        .sum_sign  (sum[W-1]),
        .cout      (cout),
        .is_sub    (is_sub),
        .is_signed (is_signed),
        .ovf_raw   (ovf_raw),
        .less      (less)
    );

    // Select the written value and qualify the trap request.
    always_comb begin
        res_next  = is_slt ? {{(W-1){1'b0}}, less} : sum;
        trap_next = in_valid && is_signed && !is_slt && ovf_raw;
    end

    // Output register stage; result and zero hold while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            zero_flag <= 1'b0;
            ovf_trap  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            ovf_trap  <= trap_next;
            if (in_valid) begin
                result    <= res_next;
                zero_flag <= (res_next == '0);
            end
        end
    end
endmodule

// File: rtl/addsub_unit_chk.sv
// Property checker for addsub_unit, attached by bind below.
// Assumes the same W as the unit it observes.
module addsub_unit_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [1:0]   op,
    input logic         is_signed,
    input logic         use_imm,
    input logic [W-1:0] a_in,
    input logic [W-1:0] b_in,
    input logic         out_valid,
    input logic [W-1:0] result,
    input logic         zero_flag,
    input logic         ovf_trap
);
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R1

    AST_ADD_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 2'b00 && !use_imm) |=> (result == $past(a_in) + $past(b_in))); // R1

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !is_signed) |=> !ovf_trap); // R3

    AST_SLT_NO_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 2'b10) |=> (!ovf_trap && result[W-1:1] == '0)); // R6

    AST_ZERO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (zero_flag == (result == '0))); // R8

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !ovf_trap && $stable(result))); // R10

    AST_TRAP_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_trap |-> out_valid); // R10
endmodule

bind addsub_unit addsub_unit_chk #(.W(W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op        (op),
    .is_signed (is_signed),
    .use_imm   (use_imm),
    .a_in      (a_in),
    .b_in      (b_in),
    .out_valid (out_valid),
    .result    (result),
    .zero_flag (zero_flag),
    .ovf_trap  (ovf_trap)
);

// File: tb/addsub_unit_tb_top.sv
`timescale 1ns/1ps
module addsub_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  op = 2'b00;
    logic        is_signed = 1'b0;
    logic        use_imm = 1'b0;
    logic [31:0] a_in = '0;
    logic [31:0] b_in = '0;
    logic [15:0] imm_in = '0;
    logic        out_valid;
    logic [31:0] result;
    logic        zero_flag;
    logic        ovf_trap;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    localparam logic [31:0] MAXP = 32'h7FFF_FFFF;
    localparam logic [31:0] MINN = 32'h8000_0000;

    always #4 clk = ~clk;

    addsub_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .is_signed(is_signed), .use_imm(use_imm), .a_in(a_in), .b_in(b_in),
        .imm_in(imm_in), .out_valid(out_valid), .result(result),
        .zero_flag(zero_flag), .ovf_trap(ovf_trap)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Run one operation and compare all outputs against the reference model.
    task automatic run_op(input string tag, input logic [1:0] o, input bit sg,
                          input bit ui, input logic [31:0] a, input logic [31:0] b,
                          input logic [15:0] im);
        logic [31:0] bb;
        logic [31:0] er;
        longint      sa;
        longint      sb;
        longint      s;
        bit          eo;
        bb = ui ? (sg ? {{16{im[15]}}, im} : {16'h0, im}) : b;
        sa = longint'($signed(a));
        sb = longint'($signed(bb));
        eo = 1'b0;
        if (o == 2'b10) begin
            er = sg ? {31'b0, ($signed(a) < $signed(bb))} : {31'b0, (a < bb)};
        end else if (o == 2'b01) begin
            er = a - bb;
            s  = sa - sb;
            eo = sg && (s > 64'sd2147483647 || s < -64'sd2147483648);
        end else begin
            er = a + bb;
            s  = sa + sb;
            eo = sg && (s > 64'sd2147483647 || s < -64'sd2147483648);
        end
        @(negedge clk);
        in_valid = 1'b1; op = o; is_signed = sg; use_imm = ui;
        a_in = a; b_in = b; imm_in = im;
        @(negedge clk);
        chk(out_valid == 1'b1, tag, "out_valid", {31'b0, out_valid}, 32'd1);
        chk(result == er, tag, "result", result, er);
        chk(zero_flag == (er == 32'd0), tag, "zero_flag", {31'b0, zero_flag}, {31'b0, (er == 32'd0)});
        chk(ovf_trap == eo, tag, "ovf_trap", {31'b0, ovf_trap}, {31'b0, eo});
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R11", "out_valid", {31'b0, out_valid}, 32'd0);
        chk(result == 32'd0, "R11", "result", result, 32'd0);
        chk(zero_flag == 1'b0, "R11", "zero_flag", {31'b0, zero_flag}, 32'd0);
        chk(ovf_trap == 1'b0, "R11", "ovf_trap", {31'b0, ovf_trap}, 32'd0);
        rst_n = 1'b1;
    endtask

    task automatic t_add();
        run_op("R1", 2'b00, 1'b1, 1'b0, 32'd5, 32'd2, 16'h0);
        run_op("R1", 2'b00, 1'b0, 1'b0, 32'hFFFF_FFF0, 32'h20, 16'h0);
        run_op("R1", 2'b11, 1'b0, 1'b0, 32'h1234_0000, 32'h0000_5678, 16'h0);
    endtask

    task automatic t_sub();
        run_op("R2", 2'b01, 1'b1, 1'b0, 32'd7, 32'd9, 16'h0);
        run_op("R2", 2'b01, 1'b0, 1'b0, 32'd7, 32'd9, 16'h0);
        run_op("R2", 2'b01, 1'b0, 1'b0, 32'hDEAD_BEEF, 32'h0000_BEEF, 16'h0);
    endtask

    task automatic t_unsigned_no_trap();
        run_op("R3", 2'b00, 1'b0, 1'b0, MAXP, 32'd1, 16'h0);
        run_op("R3", 2'b01, 1'b0, 1'b0, MINN, 32'd1, 16'h0);
        run_op("R3", 2'b00, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'd1, 16'h0);
    endtask

    task automatic t_signed_add_ovf();
        run_op("R4", 2'b00, 1'b1, 1'b0, MAXP, 32'd1, 16'h0);
        run_op("R4", 2'b00, 1'b1, 1'b0, MINN, 32'hFFFF_FFFF, 16'h0);
        run_op("R4", 2'b00, 1'b1, 1'b0, MINN, MAXP, 16'h0);
        run_op("R4", 2'b00, 1'b1, 1'b0, 32'hFFFF_FFFD, 32'hFFFF_FFFB, 16'h0);
    endtask

    task automatic t_signed_sub_ovf();
        run_op("R5", 2'b01, 1'b1, 1'b0, MINN, 32'd1, 16'h0);
        run_op("R5", 2'b01, 1'b1, 1'b0, 32'd0, MINN, 16'h0);
        run_op("R5", 2'b01, 1'b1, 1'b0, MAXP, 32'hFFFF_FFFF, 16'h0);
        run_op("R5", 2'b01, 1'b1, 1'b0, 32'hFFFF_FFFF, MINN, 16'h0);
        run_op("R5", 2'b01, 1'b1, 1'b0, MINN, 32'd0, 16'h0);
    endtask

    task automatic t_slt_signed();
        run_op("R6", 2'b10, 1'b1, 1'b0, MINN, MAXP, 16'h0);
        run_op("R6", 2'b10, 1'b1, 1'b0, MAXP, MINN, 16'h0);
        run_op("R6", 2'b10, 1'b1, 1'b0, 32'hFFFF_FFFF, 32'd0, 16'h0);
        run_op("R6", 2'b10, 1'b1, 1'b0, 32'd3, 32'd3, 16'h0);
    endtask

    task automatic t_slt_unsigned();
        run_op("R7", 2'b10, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'd0, 16'h0);
        run_op("R7", 2'b10, 1'b0, 1'b0, 32'd0, MINN, 16'h0);
        run_op("R7", 2'b10, 1'b0, 1'b0, MINN, MAXP, 16'h0);
    endtask

    task automatic t_zero();
        run_op("R8", 2'b01, 1'b1, 1'b0, 32'hCAFE_0001, 32'hCAFE_0001, 16'h0);
        run_op("R8", 2'b00, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'd1, 16'h0);
        run_op("R8", 2'b00, 1'b0, 1'b0, 32'd1, 32'd1, 16'h0);
    endtask

    task automatic t_imm();
        run_op("R9", 2'b00, 1'b1, 1'b1, 32'd100, 32'hAAAA_AAAA, 16'hFFFE);
        run_op("R9", 2'b00, 1'b0, 1'b1, 32'd100, 32'hAAAA_AAAA, 16'hFFFE);
        run_op("R9", 2'b10, 1'b1, 1'b1, 32'd0, 32'd0, 16'h8000);
        run_op("R9", 2'b01, 1'b1, 1'b1, 32'd0, 32'd0, 16'h7FFF);
    endtask

    task automatic t_idle();
        logic [31:0] held;
        run_op("R10", 2'b00, 1'b1, 1'b0, MAXP, 32'd1, 16'h0);
        held = result;
        @(negedge clk);
        in_valid = 1'b0; a_in = 32'd0; b_in = 32'd0; op = 2'b00;
        @(negedge clk);
        chk(ovf_trap == 1'b0, "R10", "trap after idle", {31'b0, ovf_trap}, 32'd0);
        chk(out_valid == 1'b0, "R10", "out_valid idle", {31'b0, out_valid}, 32'd0);
        chk(result == held, "R10", "result held", result, held);
        chk(zero_flag == 1'b0, "R10", "zero held", {31'b0, zero_flag}, 32'd0);
    endtask

    task automatic t_random();
        for (int i = 0; i < 300; i++) begin
            logic [1:0] o;
            o = 2'($urandom_range(0, 2));
            run_op(o == 2'b10 ? "R6" : (o == 2'b01 ? "R2" : "R1"), o,
                   1'($urandom_range(0, 1)), ($urandom_range(0, 7) == 0),
                   $urandom(), $urandom(), 16'($urandom()));
        end
    endtask

    initial begin
        void'($urandom(476));
        t_reset();
        t_add();
        t_sub();
        t_unsigned_no_trap();
        t_signed_add_ovf();
        t_signed_sub_ovf();
        t_slt_signed();
        t_slt_unsigned();
        t_zero();
        t_imm();
        t_idle();
        t_random();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule